// File: doc/BRIEF.md
# Dual-Output Compare Waveform Timer

This block is one timer channel running in waveform mode. A single up-counter, advanced on a selectable count tick, runs from zero to a shared period value and wraps back to zero, so both outputs share one period. Each of the two outputs is a flip-flop. It is not the result of a counter-versus-duty comparison. Its level changes only when an event fires, and the event's programmed action says what happens: drive high, drive low or leave alone. There are three event sources per output: its own duty compare, the shared period compare and a software trigger.

Software programs the channel through a plain address, data and write-strobe port. A mode register holds the tick source and the six action fields. Three compare registers hold the two duty points and the period. A command address starts or stops counting and fires software triggers. A driver gets normal polarity by clearing on the duty compare and setting on the period compare, and inverted polarity by doing the reverse. For a duty of zero or a full duty it programs no compare actions and lets the software trigger place a fixed level.

Top module: `wave_timer`

## Requirements
- R1: While reset is held and after it is released, out_a and out_b are 0, count_o is 0, counting is stopped (count_o stays 0 on every tick), every action field is "no action" and the tick source is code 0.
- R2: On a tick while counting is running, count_o moves to count_o+1, or to 0 when count_o equals the period register (address 3). The period is therefore period+1 ticks.
- R3: With the duty action of output A set to clear (code 2) and its period action set to set (code 1), out_a rises at the period compare and falls at the tick where count_o equals the duty A register (address 1).
- R4: With the duty action of output B set to set (code 1) and its period action set to clear (code 2), out_b is the inverted waveform, with the duty point taken from the duty B register (address 2).
- R5: When several events hit one output in the same cycle, the software trigger wins over the period compare, and the period compare wins over the duty compare.
- R6: A command write with bit 2 set resets count_o to 0 at that clock edge. In the same edge it applies each output's software-trigger action, whether counting is running or stopped.
- R7: When both compare actions are "no action", the output keeps the level placed by the last software trigger while the counter runs.
- R8: A command write with bit 1 set stops counting and count_o freezes. A later write with bit 0 set resumes counting from the frozen value.
- R9: Mode bits [2:0] choose the tick: code k for k=0..3 ticks once every 2^(1+2k) clocks from a free-running prescaler cleared by reset, ticking when its low 1+2k bits are all ones. Codes 4 to 7 use the slow_tick input.
- R10: A command write with both bits 0 and 1 set leaves counting stopped.
- R11: Action code 3 leaves the output unchanged, like code 0. Mode register (address 0) layout: [4:3] A duty, [6:5] A period, [8:7] A trigger, [10:9] B duty, [12:11] B period, [14:13] B trigger; codes 0 none, 1 set, 2 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | Single-cycle slow clock tick, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | 0 mode, 1 duty A, 2 duty B, 3 period, 4 command |
| wr_data | input | CNT_W | Write data; command bits 0 start, 1 stop, 2 trigger |
| out_a | output | 1 | Waveform output A |
| out_b | output | 1 | Waveform output B |
| count_o | output | CNT_W | Current counter value |

## Verification
The assertions take for granted that the period register is never lowered below the running count. If it were, the counter would climb to its full width before wrapping, which is legal but not what the stimulus is meant to explore. They also assume slow_tick is a clean one-cycle pulse. The stimulus respects both: before every reconfiguration it writes a stop-plus-trigger command, which parks the counter at zero, and only then does it load new compare values and mode. The slow tick is driven as an isolated single-cycle pulse every fifth clock.

// File: rtl/wt_pkg.sv
package wt_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_KEEP = 2'd3
  } act_e;

  typedef struct packed {
    act_e sw;
    act_e per;
    act_e duty;
  } out_cfg_t;

  localparam int SEL_W = 3;

  typedef struct packed {
    out_cfg_t         b;
    out_cfg_t         a;
    logic [SEL_W-1:0] sel;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  localparam logic [2:0] ADDR_MODE   = 3'd0;
  localparam logic [2:0] ADDR_DUTY_A = 3'd1;
  localparam logic [2:0] ADDR_DUTY_B = 3'd2;
  localparam logic [2:0] ADDR_PERIOD = 3'd3;
  localparam logic [2:0] ADDR_CMD    = 3'd4;

  localparam int CMD_ON   = 0;
  localparam int CMD_OFF  = 1;
  localparam int CMD_TRIG = 2;
endpackage

// File: rtl/wt_prescaler.sv
module wt_prescaler #(
  parameter int NUM_DIV = 4,
  parameter int STEP    = 2,
  parameter int SEL_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_tick,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int PRE_W = 1 + STEP * (NUM_DIV - 1);
  localparam int IDX_W = (NUM_DIV > 1) ? $clog2(NUM_DIV) : 1;

  logic [PRE_W-1:0]   pre_q, pre_d;
  logic [NUM_DIV-1:0] taps;

  always_comb pre_d = pre_q + PRE_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // Division k ticks when the low 1+STEP*k prescaler bits are all ones.
  for (genvar k = 0; k < NUM_DIV; k++) begin : g_tap
    localparam int HI = STEP * k;
    assign taps[k] = &pre_q[HI:0];
  end

  always_comb begin
    tick = slow_tick;
    if (int'(sel) < NUM_DIV) tick = taps[sel[IDX_W-1:0]];
  end
endmodule

// File: rtl/wt_counter.sv
module wt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             trig,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             adv,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_d;

  assign adv  = run & tick;
  assign wrap = adv & (count == period);

  always_comb begin
    cnt_d = count;
    if (trig)      cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else if (adv)  cnt_d = count + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= cnt_d;
  end
endmodule

// File: rtl/wt_out_action.sv
module wt_out_action
  import wt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             wrap,
  input  logic             trig,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] duty,
  input  out_cfg_t         cfg,
  output logic             out
);
  logic hit, out_d;

  function automatic logic apply(input act_e act, input logic cur);
    case (act)
      ACT_SET: apply = 1'b1;
      ACT_CLR: apply = 1'b0;
      default: apply = cur;
    endcase
  endfunction

  assign hit = adv & (count == duty);

  // Trigger beats period compare, period compare beats duty compare.
  always_comb begin
    out_d = out;
    if (trig)      out_d = apply(cfg.sw, out);
    else if (wrap) out_d = apply(cfg.per, out);
    else if (hit)  out_d = apply(cfg.duty, out);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out <= 1'b0;
    else        out <= out_d;
  end
endmodule

// File: rtl/wave_timer.sv
module wave_timer
  import wt_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int NUM_DIV  = 4,
  parameter int DIV_STEP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_tick,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             out_a,
  output logic             out_b,
  output logic [CNT_W-1:0] count_o
);
  localparam int NUM_CMP = 3;
  localparam int PER_IDX = 2;

  mode_t            mode_q, mode_d;
  logic [CNT_W-1:0] cmp_q [NUM_CMP];
  logic [CNT_W-1:0] cmp_d [NUM_CMP];
  logic             run_q, run_d;
  logic             sw_trig, tick, adv, wrap;
  logic [1:0]       outs;

  always_comb begin
    mode_d  = mode_q;
    run_d   = run_q;
    sw_trig = 1'b0;
    for (int i = 0; i < NUM_CMP; i++) cmp_d[i] = cmp_q[i];
    if (wr_en) begin
      case (wr_addr)
        ADDR_MODE:   mode_d = mode_t'(wr_data[MODE_W-1:0]);
        ADDR_DUTY_A: cmp_d[0] = wr_data;
        ADDR_DUTY_B: cmp_d[1] = wr_data;
        ADDR_PERIOD: cmp_d[PER_IDX] = wr_data;
        ADDR_CMD: begin
          sw_trig = wr_data[CMD_TRIG];
          if (wr_data[CMD_OFF])     run_d = 1'b0;
          else if (wr_data[CMD_ON]) run_d = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      run_q  <= 1'b0;
      for (int i = 0; i < NUM_CMP; i++) cmp_q[i] <= '0;
    end else begin
      mode_q <= mode_d;
      run_q  <= run_d;
      for (int i = 0; i < NUM_CMP; i++) cmp_q[i] <= cmp_d[i];
    end
  end

  wt_prescaler #(.NUM_DIV(NUM_DIV), .STEP(DIV_STEP), .SEL_W(SEL_W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .slow_tick (slow_tick),
    .sel       (mode_q.sel),
    .tick      (tick)
  );

  wt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .run    (run_q),
    .trig   (sw_trig),
    .period (cmp_q[PER_IDX]),
    .count  (count_o),
    .adv    (adv),
    .wrap   (wrap)
  );

  for (genvar k = 0; k < 2; k++) begin : g_out
    out_cfg_t cfg;
    assign cfg = (k == 0) ? mode_q.a : mode_q.b;
    wt_out_action #(.CNT_W(CNT_W)) u_act (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (adv),
      .wrap  (wrap),
      .trig  (sw_trig),
      .count (count_o),
      .duty  (cmp_q[k]),
      .cfg   (cfg),
      .out   (outs[k])
    );
  end

  assign out_a = outs[0];
  assign out_b = outs[1];
endmodule

// File: rtl/wt_checker.sv
module wt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             trig,
  input logic             adv,
  input logic             out_a,
  input logic             out_b,
  input logic [CNT_W-1:0] count_o,
  input logic [1:0]       sw_a
);
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o != $past(count_o)) |-> (count_o == $past(count_o) + CNT_W'(1) || count_o == '0));

  // R6
  trig_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(trig) |-> (count_o == '0));

  // R8
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(run) && !$past(trig)) |-> $stable(count_o));

  // R6
  trig_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(trig && sw_a == 2'd1) |-> out_a);

  // R11
  hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(trig) && !$past(adv)) |-> $stable(out_a));

  // R11
  hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(trig) && !$past(adv)) |-> $stable(out_b));
endmodule

bind wave_timer wt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .run     (run_q),
  .trig    (sw_trig),
  .adv     (adv),
  .out_a   (out_a),
  .out_b   (out_b),
  .count_o (count_o),
  .sw_a    (mode_q.a.sw)
);

// File: tb/wave_timer_bench.sv
module wave_timer_bench;
  localparam int CLK_P = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         slow;
  logic         we;
  logic [2:0]   addr;
  logic [W-1:0] data;
  logic         out_a, out_b;
  logic [W-1:0] count_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference state
  int m_pre, m_cnt, m_ra, m_rb, m_rc;
  bit m_en, m_a, m_b;
  logic [15:0] m_mode;

  always #(CLK_P/2) clk = ~clk;

  wave_timer #(.CNT_W(W)) u_wave_timer (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow), .wr_en(we), .wr_addr(addr),
    .wr_data(data), .out_a(out_a), .out_b(out_b), .count_o(count_o)
  );

  function automatic bit act(input logic [1:0] code, input bit cur);
    if (code == 2'd1) return 1'b1;
    if (code == 2'd2) return 1'b0;
    return cur;
  endfunction

  function automatic logic [15:0] mk(input int sel, input int ad, input int ap, input int as,
                                     input int bd, input int bp, input int bs);
    return {1'b0, 2'(bs), 2'(bp), 2'(bd), 2'(as), 2'(ap), 2'(ad), 3'(sel)};
  endfunction

  task automatic model_update();
    int sel, div, nc;
    bit tick, trig, adv, wrap, ha, hb;
    sel = int'(m_mode[2:0]);
    if (sel < 4) begin
      div  = 2 << (2 * sel);
      tick = (m_pre % div) == div - 1;
    end else tick = slow;
    trig = we && addr == 3'd4 && data[2];
    adv  = m_en && tick;
    wrap = adv && m_cnt == m_rc;
    ha   = adv && m_cnt == m_ra;
    hb   = adv && m_cnt == m_rb;
    if (trig)      begin m_a = act(m_mode[8:7], m_a);   m_b = act(m_mode[14:13], m_b); end
    else if (wrap) begin m_a = act(m_mode[6:5], m_a);   m_b = act(m_mode[12:11], m_b); end
    else begin
      if (ha) m_a = act(m_mode[4:3], m_a);
      if (hb) m_b = act(m_mode[10:9], m_b);
    end
    nc = m_cnt;
    if (trig) nc = 0;
    else if (wrap) nc = 0;
    else if (adv) nc = (m_cnt + 1) % 65536;
    m_cnt = nc;
    if (we) begin
      case (addr)
        3'd0: m_mode = {1'b0, data[14:0]};
        3'd1: m_ra = int'(data);
        3'd2: m_rb = int'(data);
        3'd3: m_rc = int'(data);
        3'd4: if (data[1]) m_en = 0; else if (data[0]) m_en = 1;
        default: ;
      endcase
    end
    m_pre = (m_pre + 1) % 128;
  endtask

  task automatic chk(input int actual, input int expected, input string tag, input string what);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, actual, expected, $time);
    end
  endtask

  task automatic step(input string ta, input string tb, input string tc);
    @(posedge clk);
    model_update();
    @(negedge clk);
    chk(int'(out_a), int'(m_a), ta, "out_a");
    chk(int'(out_b), int'(m_b), tb, "out_b");
    chk(int'(count_o), m_cnt, tc, "count_o");
  endtask

  task automatic wr(input int a, input int d, input string ta, input string tb, input string tc);
    we = 1'b1; addr = 3'(a); data = W'(d);
    step(ta, tb, tc);
    we = 1'b0;
  endtask

  task automatic idle(input int n, input int slow_per, input string ta, input string tb, input string tc);
    for (int i = 0; i < n; i++) begin
      slow = (slow_per > 0) && (i % slow_per == 0);
      step(ta, tb, tc);
    end
    slow = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; slow = 1'b0; we = 1'b0; addr = '0; data = '0;
    m_pre = 0; m_cnt = 0; m_ra = 0; m_rb = 0; m_rc = 0;
    m_en = 0; m_a = 0; m_b = 0; m_mode = '0;
    repeat (3) @(negedge clk);
    // R1: reset values while held
    chk(int'(out_a), 0, "R1", "out_a in reset");
    chk(int'(out_b), 0, "R1", "out_b in reset");
    chk(int'(count_o), 0, "R1", "count_o in reset");
    rst_n = 1'b1;
    // R1: counting stopped after reset even with ticks present
    idle(8, 2, "R1", "R1", "R1");

    // R2 R3 R4 R7: sweep period and duty
    for (int rc = 1; rc <= 5; rc++) begin
      for (int d = 0; d <= rc; d++) begin
        bit flat;
        string ta, tb;
        flat = (d == 0) || (d == rc);
        ta = flat ? "R7" : "R3";
        tb = flat ? "R7" : "R4";
        wr(4, 6, ta, tb, "R6");
        wr(1, d, ta, tb, "R2");
        wr(2, d, ta, tb, "R2");
        wr(3, rc, ta, tb, "R2");
        if (flat)
          wr(0, mk(0, 0, 0, (d == 0) ? 2 : 1, 0, 0, (d == 0) ? 1 : 2), ta, tb, "R2");
        else
          wr(0, mk(0, 2, 1, 1, 1, 2, 2), ta, tb, "R2");
        wr(4, 5, ta, tb, "R6");
        idle(4 * (rc + 1) * 2 + 3, 0, ta, tb, "R2");
      end
    end

    // R5 R6: equal duty and period, triggers at every phase
    wr(4, 6, "R5", "R5", "R6");
    wr(1, 3, "R5", "R5", "R2");
    wr(2, 1, "R5", "R5", "R2");
    wr(3, 3, "R5", "R5", "R2");
    wr(0, mk(0, 1, 2, 0, 2, 1, 2), "R5", "R5", "R2");
    wr(4, 5, "R5", "R5", "R6");
    for (int off = 0; off < 10; off++) begin
      idle(off, 0, "R5", "R5", "R2");
      wr(4, 4, "R5", "R5", "R6");
    end
    idle(12, 0, "R5", "R5", "R2");

    // R8: stop freezes, start resumes from frozen value
    wr(0, mk(0, 2, 1, 1, 1, 2, 2), "R8", "R8", "R8");
    wr(3, 9, "R8", "R8", "R8");
    wr(4, 5, "R8", "R8", "R8");
    idle(7, 0, "R8", "R8", "R8");
    wr(4, 2, "R8", "R8", "R8");
    idle(10, 0, "R8", "R8", "R8");
    wr(4, 1, "R8", "R8", "R8");
    idle(8, 0, "R8", "R8", "R8");
    wr(4, 6, "R8", "R8", "R6");
    idle(4, 0, "R8", "R8", "R8");

    // R10: start and stop together leaves the counter stopped
    wr(4, 3, "R10", "R10", "R10");
    idle(10, 0, "R10", "R10", "R10");
    wr(4, 7, "R10", "R10", "R10");
    idle(6, 0, "R10", "R10", "R10");

    // R9: each tick source
    for (int sel = 0; sel <= 4; sel++) begin
      int div;
      div = (sel < 4) ? (2 << (2 * sel)) : 5;
      wr(4, 6, "R9", "R9", "R9");
      wr(1, 1, "R9", "R9", "R9");
      wr(2, 2, "R9", "R9", "R9");
      wr(3, 2, "R9", "R9", "R9");
      wr(0, mk(sel, 2, 1, 1, 1, 2, 2), "R9", "R9", "R9");
      wr(4, 5, "R9", "R9", "R9");
      idle(9 * div + 10, 5, "R9", "R9", "R9");
    end

    // R11: action code 3 keeps the level
    wr(4, 6, "R11", "R11", "R11");
    wr(3, 4, "R11", "R11", "R11");
    wr(1, 2, "R11", "R11", "R11");
    wr(2, 2, "R11", "R11", "R11");
    wr(0, mk(0, 0, 0, 1, 0, 0, 2), "R11", "R11", "R11");
    wr(4, 4, "R11", "R11", "R11");
    wr(0, mk(0, 3, 3, 3, 3, 3, 3), "R11", "R11", "R11");
    wr(4, 5, "R11", "R11", "R11");
    idle(25, 0, "R11", "R11", "R11");
    wr(4, 4, "R11", "R11", "R11");
    idle(5, 0, "R11", "R11", "R11");
    chk(int'(out_a), 1, "R11", "out_a held high");
    chk(int'(out_b), 0, "R11", "out_b held low");

    done = 1;
    summary();
    $finish;
  end
endmodule